// File: doc/BRIEF.md
# BIST RAM Access and Address Generator

This block sits between a memory self-test sequencer and a single-port, one-bit-wide RAM with an `ADDR_W`-bit address. It holds the test address in an up/down counter. The counter can be preset at the start of a march element and stepped on the final operation of that element. The counter tells the sequencer when the address has reached the bound that ends the element.

Each sequencer command is either a write or a read of one expected bit. The block turns it into the RAM's chip select, operation line, write qualifier, address and data. Every read result is compared with the expected bit, and a registered fail flag reports any mismatch.

A test-mode input decides which side owns the RAM pins. When test mode is low, the functional port passes straight through and the RAM behaves as if no test logic were present.

Top module: `mbist_ram_access`

## Requirements
- R1: While `rst_ni` is low, `addr_o` is 0 and `fail_o` is 0.
- R2: With `test_mode_i`=0, the RAM pins follow the functional port. This means `ram_cs_o`=`sys_cs_i`, `ram_rd_o`=`sys_rd_i`, `ram_addr_o`=`sys_addr_i` and `ram_din_o`=`sys_din_i`. In this mode `sys_dout_o` equals `ram_dout_i` when `sys_cs_i`&`sys_rd_i`, and is 0 otherwise.
- R3: With `test_mode_i`=1, a write command (`op_valid_i`=1, `op_read_i`=0) drives `ram_cs_o`=1, `ram_rd_o`=0, `ram_wen_o`=1, `ram_addr_o`=`addr_o` and `ram_din_o`=`op_data_i`. The cell is written on the next rising clock edge.
- R4: With `test_mode_i`=1, a read command (`op_read_i`=1) drives `ram_cs_o`=1, `ram_rd_o`=1 and `ram_wen_o`=0. In this case `sys_dout_o` is held at 0.
- R5: With `test_mode_i`=1 and `op_valid_i`=0, `ram_cs_o` and `ram_wen_o` are 0 (storage mode).
- R6: `fail_o` is 1 for exactly the one cycle after a test-mode read in which `ram_dout_i` differed from `op_data_i`. Otherwise it is 0.
- R7: In test mode, `addr_o` steps only on an edge where `op_valid_i`&`op_last_i` is high. It steps by +1 when `order_dn_i`=0 and by −1 when `order_dn_i`=1. In all other cases, including test mode low, it holds.
- R8: In test mode, `elem_start_i`=1 presets `addr_o` to 0 when `order_dn_i`=0, or to 2^ADDR_W−1 when `order_dn_i`=1. The preset takes priority over a step in the same cycle.
- R9: `bound_o` is 1 when `addr_o` is 2^ADDR_W−1 with `order_dn_i`=0, or when `addr_o` is 0 with `order_dn_i`=1. `elem_end_o` = `op_valid_i`&`op_last_i`&`bound_o`.
- R10: Stepping past a bound wraps: 2^ADDR_W−1 steps up to 0, and 0 steps down to 2^ADDR_W−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; RAM writes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | 1: test side owns the RAM pins |
| op_valid_i | input | 1 | Sequencer command present |
| op_read_i | input | 1 | 1 read, 0 write |
| op_data_i | input | 1 | Bit to write, or bit expected on read |
| op_last_i | input | 1 | Command is the last of its element |
| order_dn_i | input | 1 | Address order: 0 ascending, 1 descending |
| elem_start_i | input | 1 | Preset counter for a new element |
| addr_o | output | ADDR_W | Current test address |
| bound_o | output | 1 | Address is at the bound for the order |
| elem_end_o | output | 1 | Last operation at the bound |
| fail_o | output | 1 | Registered read mismatch |
| sys_cs_i | input | 1 | Functional chip select |
| sys_rd_i | input | 1 | Functional operation line (1 read) |
| sys_addr_i | input | ADDR_W | Functional address |
| sys_din_i | input | 1 | Functional write data |
| sys_dout_o | output | 1 | Functional read data |
| ram_cs_o | output | 1 | RAM chip select |
| ram_rd_o | output | 1 | RAM operation line (1 read, 0 write) |
| ram_wen_o | output | 1 | Clock qualifier for a write |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_din_o | output | 1 | RAM write data |
| ram_dout_i | input | 1 | RAM asynchronous read data |

## Verification
The assertions check the following every cycle:
- the pass-through of the functional port;
- the pin pattern of test-mode writes;
- that the address holds unless stepped or preset;
- the step direction and the preset values;
- that the fail flag appears exactly one cycle after a mismatching read and at no other time.

Only the bench scenarios can show how these behaviours combine over whole march elements. These include:
- written data coming back through asynchronous reads;
- the boundary and element-end flags at both ends of the address space;
- the wrap past a bound;
- the preset winning over a simultaneous step;
- injected mismatches raising the fail flag.

// File: rtl/mbist_ra_pkg.sv
package mbist_ra_pkg;
  typedef struct packed {
    logic cs;
    logic rd;
    logic wen;
    logic din;
  } ram_ctl_t;
endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bound_o
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (en_i) begin
      if (start_i)     addr_q <= down_i ? ADDR_MAX : '0;
      else if (step_i) addr_q <= down_i ? addr_q - ADDR_ONE : addr_q + ADDR_ONE;
    end
  end

  assign addr_o  = addr_q;
  assign bound_o = down_i ? (addr_q == '0) : (addr_q == ADDR_MAX);
endmodule

// File: rtl/mbist_pin_mux.sv
module mbist_pin_mux
  import mbist_ra_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sel_test_i,
  input  ram_ctl_t          tst_ctl_i,
  input  logic [ADDR_W-1:0] tst_addr_i,
  input  ram_ctl_t          sys_ctl_i,
  input  logic [ADDR_W-1:0] sys_addr_i,
  input  logic              ram_dout_i,
  output ram_ctl_t          ram_ctl_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              sys_dout_o
);
  always_comb begin
    if (sel_test_i) begin
      ram_ctl_o  = tst_ctl_i;
      ram_addr_o = tst_addr_i;
      sys_dout_o = 1'b0;
    end else begin
      ram_ctl_o  = sys_ctl_i;
      ram_addr_o = sys_addr_i;
      // storage mode output is undriven; present it as 0
      sys_dout_o = sys_ctl_i.cs & sys_ctl_i.rd & ram_dout_i;
    end
  end
endmodule

// File: rtl/mbist_rd_cmp.sv
module mbist_rd_cmp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_i,
  input  logic exp_i,
  input  logic got_i,
  output logic fail_o
);
  logic fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else         fail_q <= chk_i & (exp_i ^ got_i);
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/mbist_ram_access.sv
module mbist_ram_access
  import mbist_ra_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_mode_i,
  input  logic              op_valid_i,
  input  logic              op_read_i,
  input  logic              op_data_i,
  input  logic              op_last_i,
  input  logic              order_dn_i,
  input  logic              elem_start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bound_o,
  output logic              elem_end_o,
  output logic              fail_o,
  input  logic              sys_cs_i,
  input  logic              sys_rd_i,
  input  logic [ADDR_W-1:0] sys_addr_i,
  input  logic              sys_din_i,
  output logic              sys_dout_o,
  output logic              ram_cs_o,
  output logic              ram_rd_o,
  output logic              ram_wen_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_din_o,
  input  logic              ram_dout_i
);
  ram_ctl_t tst_ctl, sys_ctl, ram_ctl;
  logic     step;

  assign step = op_valid_i & op_last_i;

  mbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (test_mode_i),
    .start_i (elem_start_i),
    .step_i  (step),
    .down_i  (order_dn_i),
    .addr_o  (addr_o),
    .bound_o (bound_o)
  );

  assign elem_end_o = step & bound_o;

  always_comb begin
    tst_ctl.cs  = op_valid_i;
    tst_ctl.rd  = op_read_i;
    tst_ctl.wen = op_valid_i & ~op_read_i;
    tst_ctl.din = op_data_i;
    sys_ctl.cs  = sys_cs_i;
    sys_ctl.rd  = sys_rd_i;
    sys_ctl.wen = sys_cs_i & ~sys_rd_i;
    sys_ctl.din = sys_din_i;
  end

  mbist_pin_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel_test_i (test_mode_i),
    .tst_ctl_i  (tst_ctl),
    .tst_addr_i (addr_o),
    .sys_ctl_i  (sys_ctl),
    .sys_addr_i (sys_addr_i),
    .ram_dout_i (ram_dout_i),
    .ram_ctl_o  (ram_ctl),
    .ram_addr_o (ram_addr_o),
    .sys_dout_o (sys_dout_o)
  );

  assign ram_cs_o  = ram_ctl.cs;
  assign ram_rd_o  = ram_ctl.rd;
  assign ram_wen_o = ram_ctl.wen;
  assign ram_din_o = ram_ctl.din;

  mbist_rd_cmp u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chk_i  (test_mode_i & op_valid_i & op_read_i),
    .exp_i  (op_data_i),
    .got_i  (ram_dout_i),
    .fail_o (fail_o)
  );
endmodule

// File: rtl/mbist_ram_access_chk.sv
module mbist_ram_access_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              test_mode_i,
  input logic              op_valid_i,
  input logic              op_read_i,
  input logic              op_data_i,
  input logic              op_last_i,
  input logic              order_dn_i,
  input logic              elem_start_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              fail_o,
  input logic              sys_cs_i,
  input logic              sys_rd_i,
  input logic [ADDR_W-1:0] sys_addr_i,
  input logic              sys_din_i,
  input logic              ram_cs_o,
  input logic              ram_rd_o,
  input logic              ram_wen_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_din_o,
  input logic              ram_dout_i
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i |-> (ram_cs_o == sys_cs_i) && (ram_rd_o == sys_rd_i)
                     && (ram_addr_o == sys_addr_i) && (ram_din_o == sys_din_i));

  a_r3_write_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && op_valid_i && !op_read_i |->
      ram_cs_o && !ram_rd_o && ram_wen_o && (ram_addr_o == addr_o) && (ram_din_o == op_data_i));

  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(test_mode_i && (elem_start_i || (op_valid_i && op_last_i))) |=> $stable(addr_o));

  a_r7_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && !elem_start_i && op_valid_i && op_last_i && !order_dn_i |=>
      addr_o == ADDR_W'($past(addr_o) + 1'b1));

  a_r7_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && !elem_start_i && op_valid_i && op_last_i && order_dn_i |=>
      addr_o == ADDR_W'($past(addr_o) - 1'b1));

  a_r8_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && elem_start_i |=> addr_o == ($past(order_dn_i) ? ADDR_MAX : '0));

  a_r6_fail_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && op_valid_i && op_read_i && (ram_dout_i != op_data_i) |=> fail_o);

  a_r6_fail_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> $past(test_mode_i && op_valid_i && op_read_i && (ram_dout_i != op_data_i)));
endmodule

bind mbist_ram_access mbist_ram_access_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbist_ram_access_tb_top.sv
module mbist_ram_access_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int NCEL = 1 << AW;
  localparam int AMAX = NCEL - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tm = 0, v = 0, rd = 0, dat = 0, last = 0, dn = 0, st = 0;
  logic scs = 0, srd = 0, sdin = 0;
  logic [AW-1:0] saddr = '0;
  logic [AW-1:0] addr, raddr;
  logic bnd, eend, fail, sdout, rcs, rrd, rwen, rdin, rdout;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic ram_mem [NCEL];
  int   ref_mem [NCEL];
  int   ref_addr = 0, ref_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_ram_access #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(tm), .op_valid_i(v), .op_read_i(rd),
    .op_data_i(dat), .op_last_i(last), .order_dn_i(dn), .elem_start_i(st),
    .addr_o(addr), .bound_o(bnd), .elem_end_o(eend), .fail_o(fail),
    .sys_cs_i(scs), .sys_rd_i(srd), .sys_addr_i(saddr), .sys_din_i(sdin),
    .sys_dout_o(sdout), .ram_cs_o(rcs), .ram_rd_o(rrd), .ram_wen_o(rwen),
    .ram_addr_o(raddr), .ram_din_o(rdin), .ram_dout_i(rdout)
  );

  // behavioural RAM: clocked write, asynchronous read
  always @(posedge clk) if (rwen) ram_mem[raddr] <= rdin;
  assign rdout = (rcs && rrd) ? ram_mem[raddr] : 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_cycle(string atag);
    int e_cs, e_rd, e_wen, e_addr, e_din, e_dout, e_bnd, nf;
    #1;
    chk(atag, "addr_o", addr, ref_addr);
    chk("R6", "fail_o", fail, ref_fail);
    e_bnd = dn ? (ref_addr == 0) : (ref_addr == AMAX);
    chk("R9", "bound_o", bnd, e_bnd);
    chk("R9", "elem_end_o", eend, v & last & e_bnd);
    if (tm) begin
      e_cs = v; e_rd = rd; e_wen = v & ~rd; e_addr = ref_addr; e_din = dat; e_dout = 0;
      chk(v ? (rd ? "R4" : "R3") : "R5", "ram_cs_o", rcs, e_cs);
      chk(rd ? "R4" : "R3", "ram_wen_o", rwen, e_wen);
      if (v) begin
        chk(rd ? "R4" : "R3", "ram_rd_o", rrd, e_rd);
        chk("R3", "ram_addr_o", raddr, e_addr);
      end
      chk("R4", "sys_dout_o", sdout, 0);
    end else begin
      e_cs = scs; e_rd = srd; e_wen = scs & ~srd; e_addr = saddr; e_din = sdin;
      e_dout = (scs && srd) ? ref_mem[saddr] : 0;
      chk("R2", "ram_cs_o", rcs, e_cs);
      chk("R2", "ram_rd_o", rrd, e_rd);
      chk("R2", "ram_addr_o", raddr, e_addr);
      chk("R2", "ram_din_o", rdin, e_din);
      chk("R2", "sys_dout_o", sdout, e_dout);
    end
    nf = (tm && v && rd && (ref_mem[ref_addr] != int'(dat))) ? 1 : 0;
    @(posedge clk);
    if (e_cs && !e_rd) ref_mem[e_addr] = e_din;
    ref_fail = nf;
    if (tm) begin
      if (st) ref_addr = dn ? AMAX : 0;
      else if (v && last) ref_addr = dn ? (ref_addr + AMAX) % NCEL : (ref_addr + 1) % NCEL;
    end
    @(negedge clk);
  endtask

  task automatic op(logic r, logic d, logic l, string tag);
    v = 1; rd = r; dat = d; last = l; st = 0;
    run_cycle(tag);
  endtask

  task automatic start_elem(logic down);
    v = 0; last = 0; dn = down; st = 1;
    run_cycle("R8");
    st = 0;
  endtask

  initial begin
    for (int i = 0; i < NCEL; i++) begin ram_mem[i] = 1'b0; ref_mem[i] = 0; end
    repeat (2) @(negedge clk);
    chk("R1", "addr_o in reset", addr, 0);
    chk("R1", "fail_o in reset", fail, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: functional writes and reads, test-side inputs active but ignored
    v = 1; last = 1; rd = 0; dat = 1;
    for (int i = 0; i < NCEL; i++) begin
      scs = 1; srd = 0; saddr = AW'(i); sdin = i[0];
      run_cycle("R7");
    end
    for (int i = 0; i < NCEL; i++) begin
      scs = 1; srd = 1; saddr = AW'(i);
      run_cycle("R7");
    end
    scs = 0; srd = 1;
    run_cycle("R7");
    v = 0; last = 0;

    // march: up w0; up r0,w1; down r1,w0,r0
    tm = 1;
    run_cycle("R5");
    start_elem(0);
    for (int i = 0; i < NCEL; i++) op(0, 0, 1, "R7");
    start_elem(0);
    for (int i = 0; i < NCEL; i++) begin op(1, 0, 0, "R7"); op(0, 1, 1, "R7"); end
    start_elem(1);
    for (int i = 0; i < NCEL; i++) begin
      op(1, 1, 0, "R7"); op(0, 0, 0, "R7"); op(1, 0, 1, "R7");
    end
    // counter now wrapped down past 0 (R10)
    run_cycle("R10");
    op(0, 1, 1, "R10");
    dn = 0; v = 0;
    run_cycle("R10");

    // injected mismatches: expect 1 on cells holding 0 (R6)
    start_elem(0);
    for (int i = 0; i < 4; i++) op(1, 1, 1, "R7");
    v = 0;
    run_cycle("R6");
    run_cycle("R6");

    // preset has priority over a same-cycle step (R8)
    v = 1; rd = 0; dat = 1; last = 1; dn = 1; st = 1;
    run_cycle("R8");
    st = 0; dn = 0;
    op(1, 1, 1, "R10");
    v = 0;

    // test mode low: counter holds despite last-operation commands (R7)
    tm = 0; v = 1; last = 1; scs = 0;
    run_cycle("R7");
    run_cycle("R7");
    v = 0;
    run_cycle("R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule